// File: doc/BRIEF.md
# Posted Store Buffer with Burst Coalescing

This block sits between a processor's store path and the external memory write port. Stores that miss the data cache and fall in a page marked as postable are parked in a small in-order queue, so the processor carries on without waiting for the external write. Each queued slot holds one line address, a 16-byte data field and a byte-enable mask. A cache hit is absorbed by the cache, which is told to flag its line as modified. A store that may not be posted is sent straight to memory, but only once every queued store ahead of it has left.

A single configuration bit, cleared by reset, turns posting on. With it off, every miss is handled as a direct store. When all slots are taken, a further postable store is held off with a stall until a slot frees. Stores issued as part of a multi-register store burst may be folded into the newest slot when they target the same line. Ordinary stores always take a slot of their own. Slots leave the queue in arrival order over a valid/ready handshake, and a queued store is never dropped.

Top module: `store_wbuf`

## Requirements
- R1: During reset and after its release, the queue is empty: `mem_valid` is 0, `buf_idle` is 1, `cpu_stall` is 0, and the posting enable is clear.
- R2: While the posting enable is clear, a miss to a postable page is not queued. It is presented directly on the memory port and stalls until `mem_ready`.
- R3: With the enable set, a miss to a page whose postable flag is 0 goes directly to memory. It stalls while `mem_ready` is low.
- R4: A store with `st_hit` = 1 raises `line_dirty_set` in the same cycle, does not stall, and causes no memory-port activity.
- R5: A postable miss with a free slot is accepted in the cycle it is presented, with `cpu_stall` = 0.
- R6: The queue holds DEPTH = 8 slots. With all of them occupied, a postable store that cannot be folded stalls until a slot drains.
- R7: Slots drain oldest first, one per cycle in which `mem_valid` and `mem_ready` are both 1. The presented line address, data and enables hold steady until that handshake.
- R8: A direct store stalls while any queued slot remains. It is written after all of them.
- R9: Ordinary stores (`st_burst` = 0) to one line each occupy a separate slot and produce separate writes.
- R10: A burst store is folded only into the newest slot, and only when these all hold: that slot was opened by a burst store, its line address matches, and it is not the slot currently at the head. Otherwise a new slot is opened.
- R11: Folding ORs the incoming byte enables into the slot. Enabled incoming bytes replace the stored bytes at the same positions, and other bytes are kept.
- R12: `buf_idle` is 1 exactly when no slot is occupied and no direct store is being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Write strobe for the posting enable bit |
| cfg_wb_en | input | 1 | New value of the posting enable bit |
| st_valid | input | 1 | A store is presented |
| st_la | input | LA_W (28) | Line address of the store |
| st_data | input | NBYTES*8 (128) | Store data, byte b in bits 8b+7:8b |
| st_be | input | NBYTES (16) | Byte enables, bit b enables byte b |
| st_page_buf | input | 1 | Page attribute: store may be posted |
| st_hit | input | 1 | Data cache hit with write permitted |
| st_burst | input | 1 | Store belongs to a multi-register store burst |
| cpu_stall | output | 1 | Presented store not accepted this cycle |
| line_dirty_set | output | 1 | Cache must mark the hit line modified |
| buf_idle | output | 1 | No queued slot and no direct store in flight |
| mem_valid | output | 1 | Memory write request valid |
| mem_ready | input | 1 | Memory accepts the write |
| mem_la | output | LA_W (28) | Memory write line address |
| mem_data | output | NBYTES*8 (128) | Memory write data |
| mem_be | output | NBYTES (16) | Memory write byte enables |

## Verification
A corrupted pointer or occupancy count shows up at the memory port within one handshake. A write comes out of order, is repeated, or goes missing. A stall then appears or fails to appear on the next store that meets a full queue. A wrong fold decision changes the number of writes that follow and the bytes they carry, and this is visible as soon as the queue drains. A fault in the posting-enable register or in the classification logic shows up on the first miss, which stalls when it should not, or passes when it should stall while memory is held off.

// File: rtl/store_wbuf_pkg.sv
package store_wbuf_pkg;

  // Classification of the store presented in the current cycle
  typedef enum logic [1:0] {
    ST_NONE   = 2'd0,
    ST_HIT    = 2'd1,
    ST_POST   = 2'd2,
    ST_DIRECT = 2'd3
  } st_class_e;

endpackage

// File: rtl/wbuf_policy.sv
module wbuf_policy
  import store_wbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LA_W  = 28,
  parameter int CNT_W = 4
) (
  input  logic             st_valid,
  input  logic             st_hit,
  input  logic             st_page_buf,
  input  logic             st_burst,
  input  logic [LA_W-1:0]  st_la,
  input  logic             wb_on,
  input  logic [CNT_W-1:0] count,
  input  logic [LA_W-1:0]  tail_la,
  input  logic             tail_burst,
  input  logic             mem_ready,
  output logic             push,
  output logic             merge,
  output logic             direct_valid,
  output logic             dirty_set,
  output logic             stall
);

  st_class_e cls;
  logic      q_empty;
  logic      q_full;
  logic      fold_ok;

  assign q_empty = (count == '0);
  assign q_full  = (count == CNT_W'(DEPTH));
  // newest slot must not be the head: at least two occupied
  assign fold_ok = st_burst && tail_burst && (count >= CNT_W'(2)) && (tail_la == st_la);

  always_comb begin
    cls = ST_NONE;
    if (st_valid) begin
      if (st_hit)                  cls = ST_HIT;
      else if (wb_on && st_page_buf) cls = ST_POST;
      else                         cls = ST_DIRECT;
    end
  end

  always_comb begin
    push         = 1'b0;
    merge        = 1'b0;
    direct_valid = 1'b0;
    dirty_set    = 1'b0;
    stall        = 1'b0;
    unique case (cls)
      ST_HIT:  dirty_set = 1'b1;
      ST_POST: begin
        if (fold_ok)      merge = 1'b1;
        else if (!q_full) push  = 1'b1;
        else              stall = 1'b1;
      end
      ST_DIRECT: begin
        direct_valid = q_empty;
        stall        = !(q_empty && mem_ready);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/wbuf_storage.sv
module wbuf_storage #(
  parameter int DEPTH  = 8,
  parameter int LA_W   = 28,
  parameter int NBYTES = 16,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int DATA_W = NBYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              merge,
  input  logic              pop,
  input  logic [LA_W-1:0]   in_la,
  input  logic [DATA_W-1:0] in_data,
  input  logic [NBYTES-1:0] in_be,
  input  logic              in_burst,
  output logic [CNT_W-1:0]  count,
  output logic [LA_W-1:0]   head_la,
  output logic [DATA_W-1:0] head_data,
  output logic [NBYTES-1:0] head_be,
  output logic [LA_W-1:0]   tail_la,
  output logic              tail_burst
);

  logic [PTR_W-1:0] wr_q, wr_d;
  logic [PTR_W-1:0] rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PTR_W-1:0] tail_idx;

  logic [LA_W-1:0]   la_q   [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [NBYTES-1:0] be_q   [DEPTH];
  logic              brst_q [DEPTH];
  logic [LA_W-1:0]   la_d   [DEPTH];
  logic [DATA_W-1:0] data_d [DEPTH];
  logic [NBYTES-1:0] be_d   [DEPTH];
  logic              brst_d [DEPTH];
  logic [DEPTH-1:0]  ent_we;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign tail_idx = (wr_q == '0) ? PTR_W'(DEPTH - 1) : wr_q - 1'b1;

  // pointer and occupancy next state
  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = ptr_inc(wr_q);
    if (pop)  rd_d = ptr_inc(rd_q);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // slot contents next state: open a slot or fold into the newest one
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ent_we[i] = (push && (wr_q == PTR_W'(i))) || (merge && (tail_idx == PTR_W'(i)));
      la_d[i]   = in_la;
      data_d[i] = in_data;
      be_d[i]   = in_be;
      brst_d[i] = in_burst;
      if (merge && (tail_idx == PTR_W'(i))) begin
        la_d[i]   = la_q[i];
        brst_d[i] = brst_q[i];
        be_d[i]   = be_q[i] | in_be;
        for (int b = 0; b < NBYTES; b++) begin
          data_d[i][b*8 +: 8] = in_be[b] ? in_data[b*8 +: 8] : data_q[i][b*8 +: 8];
        end
      end
    end
  end

  // data slots carry no reset; occupancy is held by the counter
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_we[i]) begin
        la_q[i]   <= la_d[i];
        data_q[i] <= data_d[i];
        be_q[i]   <= be_d[i];
        brst_q[i] <= brst_d[i];
      end
    end
  end

  assign count      = cnt_q;
  assign head_la    = la_q[rd_q];
  assign head_data  = data_q[rd_q];
  assign head_be    = be_q[rd_q];
  assign tail_la    = la_q[tail_idx];
  assign tail_burst = brst_q[tail_idx];

endmodule

// File: rtl/wbuf_port_mux.sv
module wbuf_port_mux #(
  parameter int LA_W   = 28,
  parameter int NBYTES = 16,
  localparam int DATA_W = NBYTES * 8
) (
  input  logic              has_entry,
  input  logic              direct_valid,
  input  logic [LA_W-1:0]   head_la,
  input  logic [DATA_W-1:0] head_data,
  input  logic [NBYTES-1:0] head_be,
  input  logic [LA_W-1:0]   st_la,
  input  logic [DATA_W-1:0] st_data,
  input  logic [NBYTES-1:0] st_be,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic [LA_W-1:0]   mem_la,
  output logic [DATA_W-1:0] mem_data,
  output logic [NBYTES-1:0] mem_be,
  output logic              pop
);

  // queued slots always win; a direct store is only offered on an empty queue
  assign mem_valid = has_entry || direct_valid;
  assign pop       = has_entry && mem_ready;

  always_comb begin
    if (has_entry) begin
      mem_la   = head_la;
      mem_data = head_data;
      mem_be   = head_be;
    end else begin
      mem_la   = st_la;
      mem_data = st_data;
      mem_be   = st_be;
    end
  end

endmodule

// File: rtl/store_wbuf.sv
module store_wbuf #(
  parameter int DEPTH  = 8,
  parameter int LA_W   = 28,
  parameter int NBYTES = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int DATA_W = NBYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_wb_en,
  input  logic              st_valid,
  input  logic [LA_W-1:0]   st_la,
  input  logic [DATA_W-1:0] st_data,
  input  logic [NBYTES-1:0] st_be,
  input  logic              st_page_buf,
  input  logic              st_hit,
  input  logic              st_burst,
  output logic              cpu_stall,
  output logic              line_dirty_set,
  output logic              buf_idle,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [LA_W-1:0]   mem_la,
  output logic [DATA_W-1:0] mem_data,
  output logic [NBYTES-1:0] mem_be
);

  logic rst_meta_q, rst_sync_n;
  logic wb_on_q, wb_on_d;
  logic push, merge, pop, direct_valid;
  logic [CNT_W-1:0]  count;
  logic [LA_W-1:0]   head_la, tail_la;
  logic [DATA_W-1:0] head_data;
  logic [NBYTES-1:0] head_be;
  logic              tail_burst;
  logic              has_entry;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // posting enable bit
  assign wb_on_d = cfg_wb_en;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  wb_on_q <= 1'b0;
    else if (cfg_wr)  wb_on_q <= wb_on_d;
  end

  wbuf_policy #(.DEPTH(DEPTH), .LA_W(LA_W), .CNT_W(CNT_W)) u_policy (
    .st_valid     (st_valid),
    .st_hit       (st_hit),
    .st_page_buf  (st_page_buf),
    .st_burst     (st_burst),
    .st_la        (st_la),
    .wb_on        (wb_on_q),
    .count        (count),
    .tail_la      (tail_la),
    .tail_burst   (tail_burst),
    .mem_ready    (mem_ready),
    .push         (push),
    .merge        (merge),
    .direct_valid (direct_valid),
    .dirty_set    (line_dirty_set),
    .stall        (cpu_stall)
  );

  wbuf_storage #(.DEPTH(DEPTH), .LA_W(LA_W), .NBYTES(NBYTES)) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .push       (push),
    .merge      (merge),
    .pop        (pop),
    .in_la      (st_la),
    .in_data    (st_data),
    .in_be      (st_be),
    .in_burst   (st_burst),
    .count      (count),
    .head_la    (head_la),
    .head_data  (head_data),
    .head_be    (head_be),
    .tail_la    (tail_la),
    .tail_burst (tail_burst)
  );

  assign has_entry = (count != '0);

  wbuf_port_mux #(.LA_W(LA_W), .NBYTES(NBYTES)) u_port (
    .has_entry    (has_entry),
    .direct_valid (direct_valid),
    .head_la      (head_la),
    .head_data    (head_data),
    .head_be      (head_be),
    .st_la        (st_la),
    .st_data      (st_data),
    .st_be        (st_be),
    .mem_ready    (mem_ready),
    .mem_valid    (mem_valid),
    .mem_la       (mem_la),
    .mem_data     (mem_data),
    .mem_be       (mem_be),
    .pop          (pop)
  );

  assign buf_idle = !has_entry && !direct_valid;

endmodule

// File: rtl/store_wbuf_chk.sv
module store_wbuf_chk #(
  parameter int DEPTH  = 8,
  parameter int LA_W   = 28,
  parameter int NBYTES = 16,
  parameter int CNT_W  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                st_valid,
  input logic                st_hit,
  input logic                st_page_buf,
  input logic                st_burst,
  input logic                wb_on,
  input logic [CNT_W-1:0]    count,
  input logic                push,
  input logic                merge,
  input logic                cpu_stall,
  input logic                line_dirty_set,
  input logic                buf_idle,
  input logic                mem_valid,
  input logic                mem_ready,
  input logic [LA_W-1:0]     mem_la,
  input logic [NBYTES*8-1:0] mem_data,
  input logic [NBYTES-1:0]   mem_be
);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_empty: assert (count == '0 && !wb_on);
    end
  end

  a_r4_hit_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_hit) |-> (line_dirty_set && !cpu_stall && !push && !merge));

  a_r3_plain_page_not_queued: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_hit && !(wb_on && st_page_buf)) |-> (!push && !merge));

  a_r6_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_hit && wb_on && st_page_buf && !st_burst && count == CNT_W'(DEPTH))
      |-> cpu_stall);

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  a_r7_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && count != '0)
      |=> (mem_valid && $stable(mem_la) && $stable(mem_data) && $stable(mem_be)));

  a_r9_plain_never_folds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_burst) |-> !merge);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    buf_idle |-> (!mem_valid && count == '0));

endmodule

bind store_wbuf store_wbuf_chk #(
  .DEPTH(DEPTH), .LA_W(LA_W), .NBYTES(NBYTES), .CNT_W(CNT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .st_valid       (st_valid),
  .st_hit         (st_hit),
  .st_page_buf    (st_page_buf),
  .st_burst       (st_burst),
  .wb_on          (wb_on_q),
  .count          (count),
  .push           (push),
  .merge          (merge),
  .cpu_stall      (cpu_stall),
  .line_dirty_set (line_dirty_set),
  .buf_idle       (buf_idle),
  .mem_valid      (mem_valid),
  .mem_ready      (mem_ready),
  .mem_la         (mem_la),
  .mem_data       (mem_data),
  .mem_be         (mem_be)
);

// File: tb/store_wbuf_bench.sv
`timescale 1ns/1ps
module store_wbuf_bench;

  localparam int LA_W = 28;
  localparam int NB   = 16;
  localparam int DW   = NB * 8;

  typedef struct {
    logic [LA_W-1:0] la;
    logic [DW-1:0]   data;
    logic [NB-1:0]   be;
    logic            burst;
  } item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr, cfg_wb_en;
  logic st_valid, st_page_buf, st_hit, st_burst;
  logic [LA_W-1:0] st_la;
  logic [DW-1:0]   st_data;
  logic [NB-1:0]   st_be;
  logic cpu_stall, line_dirty_set, buf_idle, mem_valid, mem_ready;
  logic [LA_W-1:0] mem_la;
  logic [DW-1:0]   mem_data;
  logic [NB-1:0]   mem_be;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    en_m   = 1'b0;
  string mon_tag = "R7";
  item_t exp_q[$];
  item_t mon_e;

  always #4 clk = ~clk;

  store_wbuf u_store_wbuf (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wb_en(cfg_wb_en),
    .st_valid(st_valid), .st_la(st_la), .st_data(st_data), .st_be(st_be),
    .st_page_buf(st_page_buf), .st_hit(st_hit), .st_burst(st_burst),
    .cpu_stall(cpu_stall), .line_dirty_set(line_dirty_set), .buf_idle(buf_idle),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_la(mem_la),
    .mem_data(mem_data), .mem_be(mem_be)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: records the expected memory write, then presents the store
  task automatic do_store(input logic [LA_W-1:0] la, input logic [DW-1:0] d,
                          input logic [NB-1:0] be, input bit pb, input bit hit,
                          input bit burst, output int stalls);
    bit acc;
    if (!hit) begin
      if (en_m && pb) begin
        if (burst && exp_q.size() >= 2 && exp_q[exp_q.size()-1].burst &&
            exp_q[exp_q.size()-1].la == la) begin
          for (int b = 0; b < NB; b++)
            if (be[b]) exp_q[exp_q.size()-1].data[b*8 +: 8] = d[b*8 +: 8];
          exp_q[exp_q.size()-1].be = exp_q[exp_q.size()-1].be | be;
        end else begin
          exp_q.push_back('{la, d, be, burst});
        end
      end else begin
        exp_q.push_back('{la, d, be, 1'b0});
      end
    end
    st_la = la; st_data = d; st_be = be; st_page_buf = pb;
    st_hit = hit; st_burst = burst; st_valid = 1'b1;
    stalls = 0;
    forever begin
      @(negedge clk);
      acc = !cpu_stall;
      @(posedge clk); #1;
      if (acc) break;
      stalls++;
    end
    st_valid = 1'b0;
  endtask

  task automatic set_en(input bit v);
    cfg_wr = 1'b1; cfg_wb_en = v;
    @(posedge clk); #1;
    cfg_wr = 1'b0; en_m = v;
  endtask

  task automatic wait_idle();
    while (!(buf_idle && exp_q.size() == 0)) begin
      @(posedge clk);
    end
    #1;
  endtask

  // monitor: pops and compares each completed memory write
  always @(negedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, mon_tag, "unexpected write line", DW'(mem_la), '0);
      end else begin
        mon_e = exp_q.pop_front();
        check(mem_la == mon_e.la, mon_tag, "write line", DW'(mem_la), DW'(mon_e.la));
        check(mem_be == mon_e.be, mon_tag, "write enables", DW'(mem_be), DW'(mon_e.be));
        check(mem_data == mon_e.data, mon_tag, "write data", mem_data, mon_e.data);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int s;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wb_en = 1'b0;
    st_valid = 1'b0; st_la = '0; st_data = '0; st_be = '0;
    st_page_buf = 1'b0; st_hit = 1'b0; st_burst = 1'b0; mem_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!mem_valid && buf_idle && !cpu_stall, "R1", "quiet in reset",
          DW'({mem_valid, buf_idle, cpu_stall}), DW'(3'b010));
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    @(negedge clk);
    check(!mem_valid && buf_idle && !cpu_stall, "R1", "quiet after reset",
          DW'({mem_valid, buf_idle, cpu_stall}), DW'(3'b010));
    @(posedge clk); #1;

    // R2: enable clear after reset, postable page still goes direct
    fork
      do_store(28'h0000_011, {4{32'h1111_2222}}, 16'hFFFF, 1'b1, 1'b0, 1'b0, s);
      begin
        repeat (3) @(negedge clk);
        check(cpu_stall, "R2", "direct store stalls", DW'(cpu_stall), DW'(1));
        check(mem_valid && !buf_idle, "R12", "direct store not idle",
              DW'({mem_valid, buf_idle}), DW'(2'b10));
        check(mem_la == 28'h0000_011, "R2", "direct line on port", DW'(mem_la), DW'(28'h11));
        @(posedge clk); #1 mem_ready = 1'b1;
      end
    join
    check(s >= 2, "R2", "stall cycles", DW'(s), DW'(2));
    wait_idle();

    set_en(1'b1);

    // R4: cache hit
    st_la = 28'h0000_022; st_be = 16'h000F; st_hit = 1'b1; st_page_buf = 1'b1;
    st_burst = 1'b0; st_valid = 1'b1;
    @(negedge clk);
    check(line_dirty_set && !cpu_stall && !mem_valid, "R4", "hit absorbed",
          DW'({line_dirty_set, cpu_stall, mem_valid}), DW'(3'b100));
    @(posedge clk); #1 st_valid = 1'b0; st_hit = 1'b0;
    @(negedge clk);
    check(buf_idle && !mem_valid, "R4", "no activity after hit",
          DW'({buf_idle, mem_valid}), DW'(2'b10));
    @(posedge clk); #1;

    // R3: enable set but page not postable
    mem_ready = 1'b0;
    fork
      do_store(28'h0000_033, {4{32'hA5A5_0033}}, 16'h00FF, 1'b0, 1'b0, 1'b0, s);
      begin
        repeat (3) @(negedge clk);
        check(cpu_stall, "R3", "plain page stalls", DW'(cpu_stall), DW'(1));
        @(posedge clk); #1 mem_ready = 1'b1;
      end
    join
    check(s >= 2, "R3", "stall cycles", DW'(s), DW'(2));
    wait_idle();

    // R5 / R6: fill all eight slots, ninth stalls
    mem_ready = 1'b0;
    for (int i = 0; i < 8; i++) begin
      do_store(28'h0000_100 + 28'(i), {4{32'hC000_0000 + 32'(i)}}, 16'hFFFF,
               1'b1, 1'b0, 1'b0, s);
      check(s == 0, "R5", "posted without stall", DW'(s), DW'(0));
    end
    check(!buf_idle, "R12", "queue occupied", DW'(buf_idle), DW'(0));
    fork
      do_store(28'h0000_1FF, {4{32'hDEAD_BEEF}}, 16'h0F0F, 1'b1, 1'b0, 1'b0, s);
      begin
        repeat (4) @(negedge clk);
        check(cpu_stall, "R6", "full queue stalls", DW'(cpu_stall), DW'(1));
        check(mem_la == 28'h0000_100, "R7", "oldest at head", DW'(mem_la), DW'(28'h100));
        @(posedge clk); #1 mem_ready = 1'b1;
      end
    join
    check(s >= 3, "R6", "stall cycles", DW'(s), DW'(3));
    wait_idle();

    // R8: direct store waits behind queued slots
    mem_ready = 1'b0;
    mon_tag = "R8";
    do_store(28'h0000_201, {4{32'h0201_0201}}, 16'hFFFF, 1'b1, 1'b0, 1'b0, s);
    do_store(28'h0000_202, {4{32'h0202_0202}}, 16'hFFFF, 1'b1, 1'b0, 1'b0, s);
    fork
      do_store(28'h0000_2DD, {4{32'h0DD0_0DD0}}, 16'hF000, 1'b0, 1'b0, 1'b0, s);
      begin
        repeat (3) @(negedge clk);
        check(cpu_stall, "R8", "direct waits for queue", DW'(cpu_stall), DW'(1));
        check(mem_la == 28'h0000_201, "R8", "queued slot first", DW'(mem_la), DW'(28'h201));
        @(posedge clk); #1 mem_ready = 1'b1;
      end
    join
    wait_idle();

    // R9: ordinary stores to one line stay separate
    mem_ready = 1'b0;
    mon_tag = "R9";
    do_store(28'h0000_300, {4{32'h3333_0000}}, 16'h000F, 1'b1, 1'b0, 1'b0, s);
    do_store(28'h0000_300, {4{32'h3333_1111}}, 16'h00F0, 1'b1, 1'b0, 1'b0, s);
    do_store(28'h0000_300, {4{32'h3333_2222}}, 16'h0F00, 1'b1, 1'b0, 1'b0, s);
    check(exp_q.size() == 3, "R9", "expected slot count", DW'(exp_q.size()), DW'(3));
    @(posedge clk); #1 mem_ready = 1'b1;
    wait_idle();

    // R10 / R11: burst folding rules
    mem_ready = 1'b0;
    mon_tag = "R10 R11";
    // head slot is never a fold target
    do_store(28'h0000_400, {4{32'h4000_0001}}, 16'h000F, 1'b1, 1'b0, 1'b1, s);
    do_store(28'h0000_400, {4{32'h4000_0002}}, 16'h00FF, 1'b1, 1'b0, 1'b1, s);
    // newest, burst-opened, not head: folds with overlap
    do_store(28'h0000_400, {4{32'h4000_0003}}, 16'h0FF0, 1'b1, 1'b0, 1'b1, s);
    // plain-opened slot is not a target
    do_store(28'h0000_500, {4{32'h5000_0001}}, 16'h0003, 1'b1, 1'b0, 1'b0, s);
    do_store(28'h0000_500, {4{32'h5000_0002}}, 16'h000C, 1'b1, 1'b0, 1'b1, s);
    do_store(28'h0000_500, {4{32'h5000_0003}}, 16'hC000, 1'b1, 1'b0, 1'b1, s);
    // different line opens a new slot
    do_store(28'h0000_600, {4{32'h6000_0001}}, 16'hFFFF, 1'b1, 1'b0, 1'b1, s);
    check(exp_q.size() == 5, "R10", "expected slot count", DW'(exp_q.size()), DW'(5));
    check(exp_q[1].be == 16'h0FFF, "R11", "model union", DW'(exp_q[1].be), DW'(16'h0FFF));
    @(posedge clk); #1 mem_ready = 1'b1;
    wait_idle();

    // R12: fully drained
    @(negedge clk);
    check(buf_idle && !mem_valid, "R12", "idle after drain",
          DW'({buf_idle, mem_valid}), DW'(2'b10));
    check(exp_q.size() == 0, "R7", "all writes seen", DW'(exp_q.size()), DW'(0));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule